// File: doc/BRIEF.md
# Two-Cycle Carry-Save Multiply-Accumulate Unit

This block multiplies two 8-bit operands and adds the product into a 20-bit running total. The operands are read as two's complement or as unsigned numbers, and a select line chooses which. The first pipeline cycle forms the partial products. A tree of 4:2 compressors reduces those rows, and the same tree also takes the running total as extra rows. The cycle ends with a registered carry-save pair. The second cycle performs the only carry-propagate addition in the block and writes the total. So the multiplier never has a final adder of its own.

A new operand pair may be accepted on every clock. When an operation is still in the second stage, its carry-save pair is fed straight back into the tree as the two accumulator rows. Back-to-back accumulation therefore needs no bubble. A clear strobe that comes with an operand pair starts a new sum from that product alone. The total wraps modulo 2^20.

Top module: `cmac`

## Requirements
- R1: `out_valid` is high in exactly the cycle after the second rising edge following a cycle in which `in_valid` was high, and it is low otherwise.
- R2: With `signed_mode`=0, each accepted pair adds the zero-extended product `op_a*op_b` (0..65025) to the total.
- R3: With `signed_mode`=1, both operands are two's complement, and the product (from -16256 to 16384) is sign-extended to 20 bits before it is added. For example, -128*127 from a zero total gives 0xFC080.
- R4: When `acc_clear` is high together with `in_valid`, the new total equals that operation's product alone.
- R5: `acc_clear` while `in_valid` is low has no effect. The total seen at `acc_out` is unchanged.
- R6: Operations accepted on consecutive cycles each accumulate onto the result of the one before, with no lost or repeated term.
- R7: The total wraps modulo 2^20 with no saturation. For example, seventeen unsigned 255*255 terms give 0x0DE11.
- R8: In a cycle when no operation completes, `acc_out` holds its value.
- R9: A synchronous high `rst` sets `acc_out` to 0 and `out_valid` to 0 from the next edge, and any operation in flight is dropped.
- R10: The compressor tree keeps the arithmetic sum. Its two output rows add, modulo 2^20, to the sum of all of its input rows.
- R11: The operand mode may differ from one accepted operation to the next, and each term uses the mode it was accepted with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair present this cycle |
| acc_clear | input | 1 | With in_valid: start a new total from this product |
| signed_mode | input | 1 | 1 = two's complement operands, 0 = unsigned |
| op_a | input | 8 | First operand |
| op_b | input | 8 | Second operand |
| acc_out | output | 20 | Registered running total |
| out_valid | output | 1 | Total updated by an operation this cycle |

## Verification
Two events can meet in one cycle. One is the stage-two write of the total. The other is the stage-one reduction of the next operation, which needs that total while it is still being written. The bench provokes this with unbroken bursts of operations and with bursts that mix modes and clears, and it also inserts single idle gaps so that both the forwarded path and the registered path are used. A behavioural model keeps the total as a plain integer in the order of acceptance, and every cycle the bench compares `acc_out` and `out_valid` with the model's two-stage delayed expectation.

// File: rtl/cmac_pkg.sv
package cmac_pkg;

  // rows left after one layer of 4:2 compression (groups padded to four)
  function automatic int next_rows(input int n);
    return (n <= 2) ? n : 2 * ((n + 3) / 4);
  endfunction

  // rows present at a given level of the tree
  function automatic int rows_at(input int n_in, input int lvl);
    int n;
    n = n_in;
    for (int i = 0; i < lvl; i++) n = next_rows(n);
    return n;
  endfunction

  // number of compressor layers needed to reach two rows
  function automatic int tree_levels(input int n_in);
    int n;
    int l;
    n = n_in;
    l = 0;
    while (n > 2) begin
      n = next_rows(n);
      l++;
    end
    return l;
  endfunction

endpackage

// File: rtl/cmac_pp_gen.sv
module cmac_pp_gen #(
  parameter int OP_W  = 8,
  parameter int ACC_W = 20
) (
  input  logic                        sgn,
  input  logic [OP_W-1:0]             a,
  input  logic [OP_W-1:0]             b,
  output logic [OP_W:0][ACC_W-1:0]    rows
);
  // correction term for the inverted sign-cross bits: 2^N - 2^(2N-1), modulo 2^ACC_W
  localparam logic [ACC_W-1:0] CORR =
    (ACC_W'(1) << OP_W) - (ACC_W'(1) << (2 * OP_W - 1));

  always_comb begin
    for (int i = 0; i < OP_W; i++) begin
      rows[i] = '0;
      for (int j = 0; j < OP_W; j++) begin
        // bits pairing exactly one sign bit are complemented in signed mode
        rows[i][i + j] = (a[j] & b[i]) ^
                         (sgn & ((i == OP_W - 1) != (j == OP_W - 1)));
      end
    end
    rows[OP_W] = sgn ? CORR : '0;
  end

endmodule

// File: rtl/cmac_csa42.sv
module cmac_csa42 #(
  parameter int W = 20
) (
  input  logic [W-1:0] x0,
  input  logic [W-1:0] x1,
  input  logic [W-1:0] x2,
  input  logic [W-1:0] x3,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] carry_o
);
  logic [W-1:0] s1;
  logic [W-1:0] cin;
  logic [W-2:0] cc;

  assign cin[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign s1[i]    = x0[i] ^ x1[i] ^ x2[i];
    assign sum_o[i] = s1[i] ^ x3[i] ^ cin[i];
    if (i < W - 1) begin : g_up
      // lateral carry taken from the first three inputs only: no ripple
      assign cin[i+1] = (x0[i] & x1[i]) | (x0[i] & x2[i]) | (x1[i] & x2[i]);
      assign cc[i]    = (s1[i] & x3[i]) | (s1[i] & cin[i]) | (x3[i] & cin[i]);
    end
  end

  assign carry_o = {cc, 1'b0};

endmodule

// File: rtl/cmac_tree.sv
module cmac_tree #(
  parameter int W    = 20,
  parameter int N_IN = 11
) (
  input  logic [N_IN-1:0][W-1:0] rows_i,
  output logic [W-1:0]           sum_o,
  output logic [W-1:0]           carry_o
);
  localparam int LEVELS = cmac_pkg::tree_levels(N_IN);

  for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
    localparam int NR = cmac_pkg::rows_at(N_IN, l);
    logic [W-1:0] r [NR];

    if (l == 0) begin : g_src
      for (genvar k = 0; k < NR; k++) begin : g_cp
        assign r[k] = rows_i[k];
      end
    end else begin : g_red
      localparam int NP = cmac_pkg::rows_at(N_IN, l - 1);
      localparam int NG = (NP + 3) / 4;
      for (genvar g = 0; g < NG; g++) begin : g_grp
        logic [W-1:0] in4 [4];
        for (genvar k = 0; k < 4; k++) begin : g_in
          if (4 * g + k < NP) begin : g_row
            assign in4[k] = g_lvl[l-1].r[4*g+k];
          end else begin : g_pad
            assign in4[k] = '0;
          end
        end
        cmac_csa42 #(.W(W)) u_csa (
          .x0     (in4[0]),
          .x1     (in4[1]),
          .x2     (in4[2]),
          .x3     (in4[3]),
          .sum_o  (r[2*g]),
          .carry_o(r[2*g+1])
        );
      end
    end
  end

  assign sum_o   = g_lvl[LEVELS].r[0];
  assign carry_o = g_lvl[LEVELS].r[1];

  // R10: reduction keeps the arithmetic total of its rows
  always_comb begin
    logic [W-1:0] tot;
    tot = '0;
    for (int k = 0; k < N_IN; k++) tot = tot + rows_i[k];
    if (!$isunknown(rows_i)) begin
      p_tree_conserve_r10: assert (tot == W'(sum_o + carry_o))
        else $error("tree lost the row total");
    end
  end

endmodule

// File: rtl/cmac.sv
module cmac #(
  parameter int OP_W  = 8,
  parameter int ACC_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             acc_clear,
  input  logic             signed_mode,
  input  logic [OP_W-1:0]  op_a,
  input  logic [OP_W-1:0]  op_b,
  output logic [ACC_W-1:0] acc_out,
  output logic             out_valid
);
  // partial-product rows + correction row + two accumulator rows
  localparam int N_ROWS = OP_W + 3;

  logic [OP_W:0][ACC_W-1:0]     pp_rows;
  logic [N_ROWS-1:0][ACC_W-1:0] tree_in;
  logic [ACC_W-1:0] acc_a, acc_b, t_sum, t_carry;
  logic [ACC_W-1:0] s1_sum, s1_carry, acc_q;
  logic             s1_v;

  cmac_pp_gen #(.OP_W(OP_W), .ACC_W(ACC_W)) u_pp (
    .sgn (signed_mode),
    .a   (op_a),
    .b   (op_b),
    .rows(pp_rows)
  );

  // accumulator rows: zero on clear, forwarded carry-save pair while the
  // previous operation is still in stage two, otherwise the stored total
  always_comb begin
    if (acc_clear) begin
      acc_a = '0;
      acc_b = '0;
    end else if (s1_v) begin
      acc_a = s1_sum;
      acc_b = s1_carry;
    end else begin
      acc_a = acc_q;
      acc_b = '0;
    end
  end

  assign tree_in = {acc_b, acc_a, pp_rows};

  cmac_tree #(.W(ACC_W), .N_IN(N_ROWS)) u_tree (
    .rows_i (tree_in),
    .sum_o  (t_sum),
    .carry_o(t_carry)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v      <= 1'b0;
      out_valid <= 1'b0;
      acc_q     <= '0;
    end else begin
      s1_v      <= in_valid;
      out_valid <= s1_v;
      if (in_valid) begin
        s1_sum   <= t_sum;
        s1_carry <= t_carry;
      end
      if (s1_v) acc_q <= s1_sum + s1_carry;  // the only carry-propagate adder
    end
  end

  assign acc_out = acc_q;

  p_accept_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> s1_v);
  p_noissue_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !s1_v);
  p_complete_r1: assert property (@(posedge clk) disable iff (rst)
    s1_v |=> out_valid);
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !s1_v |=> (!out_valid && $stable(acc_out)));
  p_reset_r9: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && acc_out == '0));

endmodule

// File: tb/cmac_bench.sv
module cmac_bench;
  localparam int OP_W  = 8;
  localparam int ACC_W = 20;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic             acc_clear = 1'b0;
  logic             signed_mode = 1'b0;
  logic [OP_W-1:0]  op_a = '0;
  logic [OP_W-1:0]  op_b = '0;
  logic [ACC_W-1:0] acc_out;
  logic             out_valid;

  int checks = 0;
  int errors = 0;
  string phase = "R9";

  // behavioural model state
  logic [ACC_W-1:0] m_acc = '0;
  logic [ACC_W-1:0] held = '0;
  logic [ACC_W-1:0] pe1 = '0, pe2 = '0;
  logic             pv1 = 1'b0, pv2 = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  cmac #(.OP_W(OP_W), .ACC_W(ACC_W)) u_cmac (
    .clk, .rst, .in_valid, .acc_clear, .signed_mode,
    .op_a, .op_b, .acc_out, .out_valid
  );

  function automatic logic [ACC_W-1:0] prod(input logic [OP_W-1:0] a,
                                            input logic [OP_W-1:0] b,
                                            input logic s);
    int ia, ib;
    ia = s ? int'($signed(a)) : int'(a);
    ib = s ? int'($signed(b)) : int'(b);
    return ACC_W'(ia * ib);
  endfunction

  always @(posedge clk) begin
    logic [ACC_W-1:0] exp_acc;
    if (rst) begin
      pv1 = 1'b0; pv2 = 1'b0; m_acc = '0; held = '0;
      exp_acc = '0;
    end else begin
      pv2 = pv1;
      pe2 = pe1;
      pv1 = in_valid;
      if (in_valid) begin
        m_acc = (acc_clear ? '0 : m_acc) + prod(op_a, op_b, signed_mode);
        pe1 = m_acc;
      end
      exp_acc = pv2 ? pe2 : held;
      held = exp_acc;
    end
    #1;
    checks++;
    if (out_valid !== (pv2 && !rst)) begin
      errors++;
      $display("FAIL R1 (%s) out_valid actual %b expected %b", phase, out_valid, pv2);
    end
    checks++;
    if (acc_out !== exp_acc) begin
      errors++;
      $display("FAIL %s acc_out actual %h expected %h", phase, acc_out, exp_acc);
    end
  end

  task automatic op(input logic [OP_W-1:0] a, input logic [OP_W-1:0] b,
                    input logic s, input logic c);
    @(negedge clk);
    in_valid = 1'b1; op_a = a; op_b = b; signed_mode = s; acc_clear = c;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0; acc_clear = 1'b0;
    end
  endtask

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R9: reset state
    phase = "R9";
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(2);

    // R2: unsigned terms with gaps (R8 hold between them)
    phase = "R2";
    op(8'd3, 8'd5, 1'b0, 1'b0); idle(3);
    op(8'd255, 8'd255, 1'b0, 1'b0); idle(2);
    phase = "R8";
    op(8'd128, 8'd2, 1'b0, 1'b0); idle(4);

    // R3: signed corner products, sign extension
    phase = "R3";
    op(8'h80, 8'h7f, 1'b1, 1'b1); idle(3);
    op(8'h80, 8'h80, 1'b1, 1'b0); idle(2);
    op(8'hff, 8'h01, 1'b1, 1'b0); idle(2);
    op(8'h7f, 8'h7f, 1'b1, 1'b0); idle(2);

    // R4: clear with operation
    phase = "R4";
    op(8'd10, 8'd20, 1'b0, 1'b1); idle(3);

    // R5: clear alone has no effect
    phase = "R5";
    @(negedge clk); in_valid = 1'b0; acc_clear = 1'b1;
    @(negedge clk); acc_clear = 1'b0;
    idle(3);

    // R7: wrap modulo 2^20 with back-to-back unsigned maxima
    phase = "R7";
    op(8'd255, 8'd255, 1'b0, 1'b1);
    for (int i = 0; i < 16; i++) op(8'd255, 8'd255, 1'b0, 1'b0);
    idle(3);

    // R6: back-to-back forwarding, including clear in the middle of a burst
    phase = "R6";
    op(8'd1, 8'd1, 1'b0, 1'b1);
    op(8'd2, 8'd3, 1'b0, 1'b0);
    op(8'd4, 8'd5, 1'b0, 1'b0);
    op(8'd7, 8'd9, 1'b0, 1'b1);
    op(8'd11, 8'd13, 1'b0, 1'b0);
    idle(1);
    op(8'd6, 8'd6, 1'b0, 1'b0);
    idle(3);

    // R11: modes alternating within a burst
    phase = "R11";
    op(8'hff, 8'hff, 1'b1, 1'b1);
    op(8'hff, 8'hff, 1'b0, 1'b0);
    op(8'h80, 8'h01, 1'b1, 1'b0);
    op(8'h80, 8'h01, 1'b0, 1'b0);
    idle(3);

    // R9: reset with operations in flight
    phase = "R9";
    op(8'd50, 8'd50, 1'b0, 1'b0);
    op(8'd60, 8'd60, 1'b0, 1'b0);
    @(negedge clk); in_valid = 1'b0; rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    idle(3);

    // R10: random mix exercising the whole tree
    phase = "R10";
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      in_valid    = ($urandom % 10) < 7;
      acc_clear   = ($urandom % 10) == 0;
      signed_mode = $urandom % 2;
      op_a        = OP_W'($urandom);
      op_b        = OP_W'($urandom);
    end
    idle(4);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule